// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog on a simple 32-bit register bus. Software writes the control word once after power-on reset. That single write sets the reload count, the action taken on expiry, the clock prescale and the debug freeze. It also locks all of these settings until the next power-on reset. Once the block is enabled, a down-counter runs from the reload value. It steps on every clock, or on every `PRESCALE_DIV` clocks when the prescale bit is set.

To keep the system alive, software writes a two-word key to the service register, and the order of the two words matters. If the counter reaches zero and steps again before a valid key arrives, the block acts according to the mode bit. In reset mode it issues a one-cycle reset request and sets a sticky status flag. In interrupt mode it raises an interrupt and reloads the counter. The status flag survives the system reset, so boot software can tell that the last reset came from the watchdog. Writing 1 to the flag clears it.

The nominal timeout is (reload + 1) × divisor ÷ clock frequency.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset (`por_n` low), every register reads zero and `irq` and `rst_req` are low.
- R2: `bus_addr` selects a register by word:
  - 0 is control, with the reload count in bits 31:16, freeze in bit 3, enable in bit 2, mode in bit 1 (1 = reset, 0 = interrupt) and prescale in bit 0.
  - 1 is the read-only count, in bits 15:0.
  - 2 is service, using bits 15:0.
  - 3 is status, with the watchdog-reset flag in bit 0.
- R3: The first control write after power-on reset captures every control field and locks them. Later control writes change nothing, and a readback returns the locked values. If the locked enable is 0, the counter stays at 0.
- R4: The enabling control write loads the counter with the reload value. Each tick decrements the counter. A tick is every clock when prescale is 0, and every `PRESCALE_DIV` clocks when it is 1. A tick that finds the counter at 0 is an expiry, and the counter reloads.
- R5: Writing 0x556C and then 0xAA39 as consecutive service writes reloads the counter, clears the prescaler and clears `irq`. This happens only while the block is enabled.
- R6: Any other service sequence causes no reload. This includes the keys in reverse order, a wrong second word, or the first key written twice. Any service value other than 0x556C disarms the sequence.
- R7: In interrupt mode, expiry sets `irq`. `irq` then stays high until a valid key sequence.
- R8: In reset mode, expiry drives `rst_req` high for exactly one cycle and sets status bit 0.
- R9: Status bit 0 survives `rst_n`. It is cleared by power-on reset or by writing 1 to it. Writing 0 to it has no effect.
- R10: A system reset (`rst_n` low) reloads the counter from the locked reload value (0 if disabled). It also clears the prescaler, the key sequence and `irq`. The locked control fields are kept.
- R11: While the freeze bit is set and `dbg_halt` is high, the counter and the prescaler hold. `dbg_halt` has no effect when the freeze bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| rst_n | input | 1 | System reset, synchronous, active low; keeps the lock and the status flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dbg_halt | input | 1 | Debug halt; freezes the counter when the freeze bit is set |
| irq | output | 1 | Expiry interrupt, held until serviced |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
Most internal faults show up on the count readback, which the bench reads after every stimulus:
- A key sequencer that is armed when it should not be shows in the first cycle after the second key, as a count that jumped back to the reload value instead of falling by two.
- A lock that fails to hold shows as a control readback that differs from the first value written, immediately after the later write.
- A mis-sized prescaler or an off-by-one expiry moves the cycle in which `irq` or `rst_req` rises. The bench samples that exact cycle and the cycle before it.
- A status flag that is lost on the system reset shows on the first read of the status register after `rst_n` is released.

// File: rtl/wdog_pkg.sv
// Shared definitions for the keyed-service watchdog.
// Assumes a word-addressed register bus with four registers.
package wdog_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_SVC  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam logic [15:0] KEY_ARM  = 16'h556C;
    localparam logic [15:0] KEY_FIRE = 16'hAA39;

    typedef struct packed {
        logic [15:0] reload;
        logic        frz;
        logic        en;
        logic        rst_mode;
        logic        pre_en;
    } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
// Control lock and sticky status flag, plus the read mux.
// Assumes the control register may be written once per power-on reset;
// the status flag is cleared only by por_n or by a write of 1.
module wdog_regs
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             fire_rst,
    input  logic [15:0]      count,
    output wdog_cfg_t        cfg,
    output logic             locked,
    output logic             stat_flag,
    output logic             start,
    output logic [31:0]      rdata
);
    logic ctrl_hit;

    assign ctrl_hit = wr_en && (addr == ADDR_CTRL) && !locked;
    // The first control write that enables the block starts the counter.
    assign start    = ctrl_hit && wdata[2];

    // Capture and lock the control fields on the first control write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cfg    <= '0;
            locked <= 1'b0;
        end else if (ctrl_hit) begin
            cfg.reload   <= wdata[31:16];
            cfg.frz      <= wdata[3];
            cfg.en       <= wdata[2];
            cfg.rst_mode <= wdata[1];
            cfg.pre_en   <= wdata[0];
            locked       <= 1'b1;
        end
    end

    // Sticky watchdog-reset flag; a new expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!por_n)
            stat_flag <= 1'b0;
        else if (fire_rst)
            stat_flag <= 1'b1;
        else if (wr_en && (addr == ADDR_STAT) && wdata[0])
            stat_flag <= 1'b0;
    end

    // Read data selected by word address.
    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = {cfg.reload, 12'b0, cfg.frz, cfg.en, cfg.rst_mode, cfg.pre_en};
            ADDR_CNT:  rdata = {16'b0, count};
            ADDR_STAT: rdata = {31'b0, stat_flag};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_keyseq.sv
// Two-word service key tracker.
// Assumes the first key arms the tracker, the second key written
// directly after it fires, and any other service value disarms it.
module wdog_keyseq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic        svc_ok
);
    logic armed;
    logic svc_hit;

    assign svc_hit = wr_en && (addr == ADDR_SVC);
    assign svc_ok  = svc_hit && armed && (wdata == KEY_FIRE);

    // Arm on the first key; every other service write disarms.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n)
            armed <= 1'b0;
        else if (svc_hit)
            armed <= (wdata == KEY_ARM);
    end
endmodule

// File: rtl/wdog_count.sv
// Prescaler, down-counter and expiry actions.
// Assumes cfg is stable once enabled; expiry is a tick with the count at 0.
module wdog_count
    import wdog_pkg::*;
#(
    parameter int PRESCALE_DIV = 65536
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  wdog_cfg_t   cfg,
    input  logic        start,
    input  logic [15:0] start_val,
    input  logic        svc_ok,
    input  logic        dbg_halt,
    output logic [15:0] count,
    output logic        irq,
    output logic        rst_req,
    output logic        fire_rst
);
    localparam int PW = (PRESCALE_DIV > 2) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE_DIV - 1);

    logic [PW-1:0] pre_cnt;
    logic          hold;
    logic          tick;
    logic          expire;

    assign hold     = cfg.frz && dbg_halt;
    assign tick     = cfg.en && !hold && (!cfg.pre_en || (pre_cnt == PRE_LAST));
    assign expire   = tick && (count == 16'd0) && !svc_ok;
    assign fire_rst = expire && cfg.rst_mode;

    // Counter, prescaler and expiry outputs.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            count   <= '0;
            pre_cnt <= '0;
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else if (!rst_n) begin
            count   <= cfg.en ? cfg.reload : 16'd0;
            pre_cnt <= '0;
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (start) begin
                count   <= start_val;
                pre_cnt <= '0;
            end else if (svc_ok && cfg.en) begin
                count   <= cfg.reload;
                pre_cnt <= '0;
                irq     <= 1'b0;
            end else if (cfg.en && !hold) begin
                if (cfg.pre_en)
                    pre_cnt <= (pre_cnt == PRE_LAST) ? '0 : pre_cnt + 1'b1;
                if (tick) begin
                    if (count == 16'd0) begin
                        count <= cfg.reload;
                        if (cfg.rst_mode)
                            rst_req <= 1'b1;
                        else
                            irq <= 1'b1;
                    end else begin
                        count <= count - 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
// Keyed-service watchdog top: connects the register file, key tracker
// and counter. Assumes synchronous active-low resets; por_n is the
// only reset that releases the control lock and the status flag.
module keyed_wdog
    import wdog_pkg::*;
#(
    parameter int PRESCALE_DIV = 65536
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dbg_halt,
    output logic        irq,
    output logic        rst_req
);
    wdog_cfg_t   cfg;
    logic        locked;
    logic        stat_flag;
    logic        start;
    logic        svc_ok;
    logic        fire_rst;
    logic [15:0] count;
    logic        unused_wbits;

    assign unused_wbits = ^bus_wdata[15:4];

    wdog_regs u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .fire_rst  (fire_rst),
        .count     (count),
        .cfg       (cfg),
        .locked    (locked),
        .stat_flag (stat_flag),
        .start     (start),
        .rdata     (bus_rdata)
    );

    wdog_keyseq u_keyseq (
        .clk    (clk),
        .por_n  (por_n),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata[15:0]),
        .svc_ok (svc_ok)
    );

    wdog_count #(.PRESCALE_DIV(PRESCALE_DIV)) u_count (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .start     (start),
        .start_val (bus_wdata[31:16]),
        .svc_ok    (svc_ok),
        .dbg_halt  (dbg_halt),
        .count     (count),
        .irq       (irq),
        .rst_req   (rst_req),
        .fire_rst  (fire_rst)
    );
endmodule

// File: rtl/keyed_wdog_chk.sv
// Property checker for keyed_wdog, attached by bind.
module keyed_wdog_chk
    import wdog_pkg::*;
(
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        dbg_halt,
    input logic        irq,
    input logic        rst_req,
    input wdog_cfg_t   cfg,
    input logic        locked,
    input logic        stat_flag,
    input logic [15:0] count,
    input logic        svc_ok
);
    // R7
    irq_release_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ($fell(irq) && $past(rst_n) && $past(por_n)) |->
            $past(bus_wr && (bus_addr == ADDR_SVC) && (bus_wdata[15:0] == KEY_FIRE)));

    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        rst_req |=> !rst_req);

    // R8
    rst_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        rst_req |-> stat_flag);

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (locked && $past(locked) && $past(por_n)) |-> $stable(cfg));

    // R11
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (locked && cfg.frz && dbg_halt && !svc_ok) |=> $stable(count));

    // R5
    svc_reload_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (svc_ok && cfg.en) |=> (count == cfg.reload));

    // R7
    action_excl_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !(irq && rst_req));
endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .dbg_halt  (dbg_halt),
    .irq       (irq),
    .rst_req   (rst_req),
    .cfg       (cfg),
    .locked    (locked),
    .stat_flag (stat_flag),
    .count     (count),
    .svc_ok    (svc_ok)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
    import wdog_pkg::*;

    logic        clk;
    logic        por_n;
    logic        rst_n;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        dbg_halt;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // key table: first word, second word, reload expected
    localparam logic [32:0] KEY_TAB [5] = '{
        {16'h556C, 16'hAA39, 1'b1},
        {16'hAA39, 16'h556C, 1'b0},
        {16'h556C, 16'h1234, 1'b0},
        {16'h556C, 16'h556C, 1'b0},
        {16'h1234, 16'hAA39, 1'b0}
    };

    keyed_wdog #(.PRESCALE_DIV(4)) u_keyed_wdog (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_halt  (dbg_halt),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_por();
        por_n = 1'b0;
        step(1);
        por_n = 1'b1;
    endtask

    task automatic do_sysrst();
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        por_n = 1'b0; rst_n = 1'b1; bus_wr = 1'b0; bus_addr = '0;
        bus_wdata = '0; dbg_halt = 1'b0;
        @(negedge clk);
        do_por();

        // R1: reset state
        rd(ADDR_CTRL, d); chk("R1", "ctrl after por", d, 32'h0);
        rd(ADDR_CNT, d);  chk("R1", "count after por", d, 32'h0);
        rd(ADDR_STAT, d); chk("R1", "status after por", d, 32'h0);
        chk("R1", "irq after por", {31'b0, irq}, 32'h0);
        chk("R1", "rst_req after por", {31'b0, rst_req}, 32'h0);

        // R3/R4: first write locks, counter loads and decrements
        wr(ADDR_CTRL, 32'h0014_0004);
        rd(ADDR_CTRL, d); chk("R3", "ctrl readback", d, 32'h0014_0004);
        rd(ADDR_CNT, d);  chk("R4", "load on enable", d, 32'd20);
        wr(ADDR_CTRL, 32'h0005_0000);
        rd(ADDR_CTRL, d); chk("R3", "second write ignored", d, 32'h0014_0004);
        rd(ADDR_CNT, d);  chk("R4", "decrement per clock", d, 32'd19);

        // R3: locked disabled stays disabled
        do_por();
        wr(ADDR_CTRL, 32'h0005_0000);
        wr(ADDR_CTRL, 32'h0005_0004);
        step(3);
        rd(ADDR_CNT, d);  chk("R3", "disabled count", d, 32'd0);
        rd(ADDR_CTRL, d); chk("R3", "disabled lock", d, 32'h0005_0000);

        // R5/R6: key sequence table
        foreach (KEY_TAB[i]) begin
            do_por();
            wr(ADDR_CTRL, 32'h0014_0004);
            step(5);
            wr(ADDR_SVC, {16'h0, KEY_TAB[i][32:17]});
            wr(ADDR_SVC, {16'h0, KEY_TAB[i][16:1]});
            rd(ADDR_CNT, d);
            chk(KEY_TAB[i][0] ? "R5" : "R6", $sformatf("key row %0d", i), d,
                KEY_TAB[i][0] ? 32'd20 : 32'd13);
        end

        // R7: interrupt mode expiry and hold
        do_por();
        wr(ADDR_CTRL, 32'h0003_0004);
        step(3);
        rd(ADDR_CNT, d); chk("R4", "count at zero", d, 32'd0);
        chk("R7", "irq before expiry", {31'b0, irq}, 32'h0);
        step(1);
        chk("R7", "irq on expiry", {31'b0, irq}, 32'h1);
        rd(ADDR_CNT, d); chk("R4", "reload on expiry", d, 32'd3);
        chk("R7", "no rst_req in irq mode", {31'b0, rst_req}, 32'h0);
        step(2);
        chk("R7", "irq held", {31'b0, irq}, 32'h1);
        wr(ADDR_SVC, 32'h556C);
        chk("R7", "irq held after first key", {31'b0, irq}, 32'h1);
        wr(ADDR_SVC, 32'hAA39);
        chk("R7", "irq cleared by service", {31'b0, irq}, 32'h0);
        rd(ADDR_CNT, d); chk("R5", "reload after service", d, 32'd3);

        // R8/R9/R10: reset mode
        do_por();
        wr(ADDR_CTRL, 32'h0003_0006);
        step(3);
        chk("R8", "rst_req before expiry", {31'b0, rst_req}, 32'h0);
        step(1);
        chk("R8", "rst_req on expiry", {31'b0, rst_req}, 32'h1);
        rd(ADDR_STAT, d); chk("R8", "status set", d, 32'h1);
        chk("R8", "no irq in reset mode", {31'b0, irq}, 32'h0);
        step(1);
        chk("R8", "rst_req one cycle", {31'b0, rst_req}, 32'h0);
        wr(ADDR_STAT, 32'h0);
        rd(ADDR_STAT, d); chk("R9", "write 0 keeps flag", d, 32'h1);
        do_sysrst();
        rd(ADDR_CNT, d);  chk("R10", "count reloads on rst_n", d, 32'd3);
        rd(ADDR_STAT, d); chk("R9", "flag survives rst_n", d, 32'h1);
        rd(ADDR_CTRL, d); chk("R10", "lock kept on rst_n", d, 32'h0003_0006);
        wr(ADDR_STAT, 32'h1);
        rd(ADDR_STAT, d); chk("R9", "write 1 clears", d, 32'h0);

        // R10: system reset disarms the key
        do_por();
        wr(ADDR_CTRL, 32'h0014_0004);
        wr(ADDR_SVC, 32'h556C);
        do_sysrst();
        wr(ADDR_SVC, 32'hAA39);
        rd(ADDR_CNT, d); chk("R10", "key disarmed by rst_n", d, 32'd19);

        // R4: prescaled ticks (divisor 4 in this bench)
        do_por();
        wr(ADDR_CTRL, 32'h0002_0005);
        step(3);
        rd(ADDR_CNT, d); chk("R4", "prescale holds", d, 32'd2);
        step(1);
        rd(ADDR_CNT, d); chk("R4", "prescale tick", d, 32'd1);
        step(4);
        rd(ADDR_CNT, d); chk("R4", "prescale second tick", d, 32'd0);
        chk("R7", "no irq before prescaled expiry", {31'b0, irq}, 32'h0);
        step(4);
        chk("R7", "irq on prescaled expiry", {31'b0, irq}, 32'h1);

        // R11: freeze with debug halt
        do_por();
        wr(ADDR_CTRL, 32'h000A_000C);
        dbg_halt = 1'b1;
        step(5);
        rd(ADDR_CNT, d); chk("R11", "frozen count", d, 32'd10);
        dbg_halt = 1'b0;
        step(2);
        rd(ADDR_CNT, d); chk("R11", "runs after halt", d, 32'd8);
        do_por();
        wr(ADDR_CTRL, 32'h000A_0004);
        dbg_halt = 1'b1;
        step(3);
        rd(ADDR_CNT, d); chk("R11", "halt ignored without freeze", d, 32'd7);
        dbg_halt = 1'b0;

        // R2: service register reads zero
        rd(ADDR_SVC, d); chk("R2", "service reads zero", d, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule